// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block runs on the host side of a parallel NOR flash. After software has written the final command word of a program or erase, it starts the poller with one pulse. The pulse carries the operation kind, the word that should end up in the array, the target address, the detection method and a poll budget. The poller then issues single-word reads through a simple request/acknowledge read port. It reads status bits until the device shows that the internal operation has stopped, waits for the rest of the data bus to settle, and compares the whole word.

There are two detection methods. In data-complement polling, bit 7 of every read is compared with the value it should finally hold. In toggle polling, bit 6 is watched; while the device is busy it flips on every read. A status read can coincide with the end of the internal write and so look like a mismatch. For that reason, a failed full-word compare is confirmed by two more reads of the same location. The operation ends with a one-cycle `done` pulse. Sticky `fail` and `timeout` flags then hold the outcome until the next accepted start.

State machine: IDLE waits for `start` (IDLE->POLL). POLL issues status reads back to back. It moves to SETTLE when the read shows completion, and to FIN with timeout when the budget runs out. SETTLE holds off reads for the settle interval (SETTLE->VERIFY). VERIFY does one full-word compare: a match goes to FIN, a mismatch goes to RECHK1. RECHK1 and RECHK2 are the two confirming reads (RECHK1->RECHK2->FIN). FIN raises `done` for one cycle and returns to IDLE.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `busy`, `done`, `fail`, `timeout` and `rd_req` are all 0.
- R2: A `start` seen while idle is accepted. It captures the mode, method, expected word, address and budget, and clears `fail` and `timeout`. `busy` is 1 from the next cycle until `done`. A `start` seen while busy is ignored: the read count, the address and the outcome of the running operation are unchanged.
- R3: Every read drives the captured address. `rd_req` stays high and `rd_addr` stays stable until `rd_ack`. No read is requested while idle.
- R4: In data-complement mode for a program, a status read shows completion when its bit 7 equals bit 7 of the expected word. Otherwise it counts as an in-progress read.
- R5: In data-complement mode for an erase, a status read shows completion when bit 7 is 1. The word used for the full-word compare is all ones, and the expected-word input is ignored.
- R6: In toggle mode, the operation counts as stopped when bit 6 of a status read equals bit 6 of the read just before it. The first status read of an operation never counts as stopped.
- R7: After the read that shows completion is acknowledged, no read is requested for SETTLE_CYC = CLK_HZ/1e6 cycles. The verify read request rises exactly SETTLE_CYC cycles after that acknowledge is taken.
- R8: If the verify read matches the compare word, the operation succeeds. If it does not, exactly two more reads follow. The operation succeeds only if both of them match; otherwise `fail` is set.
- R9: Each in-progress status read uses one unit of the budget. When max(`max_polls`,1) such reads have been made, `timeout` is set and no further reads are issued.
- R10: `done` is a one-cycle pulse at the end of every operation. `fail` and `timeout` are never both set, and they hold their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| is_erase | input | 1 | 1 = erase operation, 0 = program |
| use_toggle | input | 1 | 1 = toggle polling (bit 6), 0 = data-complement polling (bit 7) |
| exp_data | input | DW | Word expected at the target after a program |
| tgt_addr | input | AW | Address to poll |
| max_polls | input | PW | Budget of in-progress status reads (0 acts as 1) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | DW | Read data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Sticky: final compare failed |
| timeout | output | 1 | Sticky: budget exhausted before completion |

## Verification
A state machine stuck in, or wrongly leaving, POLL appears at the ports as a read count that differs from the one predicted from the busy-read count, the method and the budget. That difference is visible at the `done` pulse of the same operation. A settle counter that is off by one appears at the verify read, whose request rises one cycle too early or too late after the completing acknowledge. A wrong confirmation path shows up as an outcome or read count that disagrees with the number of glitched reads the bench injected. A start that is not ignored while busy shows up as reads to a changed address.

// File: rtl/poll_pkg.sv
package poll_pkg;

    // Status bit positions are fixed by the flash's status protocol.
    localparam int STS_BIT = 7;
    localparam int TGL_BIT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_SETTLE,
        ST_VERIFY,
        ST_RECHK1,
        ST_RECHK2,
        ST_FIN
    } poll_state_t;

endpackage

// File: rtl/poll_settle_timer.sv
module poll_settle_timer #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Last cycle of the hold-off window
    assign expire = (cnt == CW'(1));

endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [PW-1:0] limit,
    output logic          last
);
    logic [PW-1:0] used;
    logic [PW:0]   limit_eff;

    assign limit_eff = (limit == '0) ? (PW+1)'(1) : {1'b0, limit};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (clear) begin
            used <= '0;
        end else if (tick) begin
            used <= used + 1'b1;
        end
    end

    // The next in-progress read would consume the final unit
    assign last = (({1'b0, used} + 1'b1) >= limit_eff);

    // R9
    budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, used} < limit_eff));

endmodule

// File: rtl/poll_status_eval.sv
module poll_status_eval
    import poll_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] word,
    input  logic [DW-1:0] ref_word,
    input  logic          toggle_mode,
    input  logic          erase_mode,
    input  logic          have_prev,
    input  logic          prev_tgl,
    output logic          stopped,
    output logic          match
);
    logic data_done;
    logic tgl_done;

    always_comb begin
        if (erase_mode) begin
            data_done = word[STS_BIT];
        end else begin
            data_done = (word[STS_BIT] == ref_word[STS_BIT]);
        end
        tgl_done = have_prev && (word[TGL_BIT] == prev_tgl);
        stopped  = toggle_mode ? tgl_done : data_done;
        match    = (word == ref_word);
    end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import poll_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 18,
    parameter int PW     = 8,
    parameter int CLK_HZ = 100_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_erase,
    input  logic          use_toggle,
    input  logic [DW-1:0] exp_data,
    input  logic [AW-1:0] tgt_addr,
    input  logic [PW-1:0] max_polls,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          timeout
);
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;

    poll_state_t state, state_nxt;

    logic          cap_erase;
    logic          cap_tog;
    logic [DW-1:0] cap_ref;
    logic [AW-1:0] cap_addr;
    logic [PW-1:0] cap_limit;
    logic          have_prev;
    logic          prev_tgl;
    logic          rechk_ok;
    logic          fail_q;
    logic          tout_q;

    logic accept;
    logic st_stopped;
    logic word_match;
    logic budget_last;
    logic budget_tick;
    logic enter_settle;
    logic settle_done;
    logic set_fail;
    logic set_tout;

    assign accept = (state == ST_IDLE) && start;

    poll_status_eval #(.DW(DW)) u_eval (
        .word        (rd_data),
        .ref_word    (cap_ref),
        .toggle_mode (cap_tog),
        .erase_mode  (cap_erase),
        .have_prev   (have_prev),
        .prev_tgl    (prev_tgl),
        .stopped     (st_stopped),
        .match       (word_match)
    );

    poll_budget #(.PW(PW)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (budget_tick),
        .limit (cap_limit),
        .last  (budget_last)
    );

    poll_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (enter_settle),
        .expire (settle_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt    = state;
        budget_tick  = 1'b0;
        enter_settle = 1'b0;
        set_fail     = 1'b0;
        set_tout     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_POLL;
                end
            end
            ST_POLL: begin
                if (rd_ack) begin
                    if (st_stopped) begin
                        state_nxt    = ST_SETTLE;
                        enter_settle = 1'b1;
                    end else if (budget_last) begin
                        state_nxt = ST_FIN;
                        set_tout  = 1'b1;
                    end else begin
                        budget_tick = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    state_nxt = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (rd_ack) begin
                    state_nxt = word_match ? ST_FIN : ST_RECHK1;
                end
            end
            ST_RECHK1: begin
                if (rd_ack) begin
                    state_nxt = ST_RECHK2;
                end
            end
            ST_RECHK2: begin
                if (rd_ack) begin
                    state_nxt = ST_FIN;
                    set_fail  = !(rechk_ok && word_match);
                end
            end
            ST_FIN: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // Captured request and per-operation tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_erase <= 1'b0;
            cap_tog   <= 1'b0;
            cap_ref   <= '0;
            cap_addr  <= '0;
            cap_limit <= '0;
            have_prev <= 1'b0;
            prev_tgl  <= 1'b0;
            rechk_ok  <= 1'b0;
            fail_q    <= 1'b0;
            tout_q    <= 1'b0;
        end else begin
            if (accept) begin
                cap_erase <= is_erase;
                cap_tog   <= use_toggle;
                cap_ref   <= is_erase ? '1 : exp_data;
                cap_addr  <= tgt_addr;
                cap_limit <= max_polls;
                have_prev <= 1'b0;
                fail_q    <= 1'b0;
                tout_q    <= 1'b0;
            end
            if (state == ST_POLL && rd_ack) begin
                have_prev <= 1'b1;
                prev_tgl  <= rd_data[TGL_BIT];
            end
            if (state == ST_RECHK1 && rd_ack) begin
                rechk_ok <= word_match;
            end
            if (set_fail) begin
                fail_q <= 1'b1;
            end
            if (set_tout) begin
                tout_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_req  = (state == ST_POLL) || (state == ST_VERIFY) ||
                  (state == ST_RECHK1) || (state == ST_RECHK2);
        rd_addr = cap_addr;
        busy    = (state != ST_IDLE);
        done    = (state == ST_FIN);
        fail    = fail_q;
        timeout = tout_q;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);

    // R2
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cap_addr));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail && timeout));

    // R9
    timeout_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(rd_ack));

endmodule

// File: tb/flash_done_poller_test.sv
module flash_done_poller_test;
    localparam int DW     = 16;
    localparam int AW     = 18;
    localparam int PW     = 8;
    localparam int CLK_HZ = 100_000_000;
    localparam int SETTLE = CLK_HZ / 1_000_000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          is_erase = 1'b0;
    logic          use_toggle = 1'b0;
    logic [DW-1:0] exp_data = '0;
    logic [AW-1:0] tgt_addr = '0;
    logic [PW-1:0] max_polls = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          busy, done, fail, timeout;

    flash_done_poller #(.DW(DW), .AW(AW), .PW(PW), .CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_erase(is_erase),
        .use_toggle(use_toggle), .exp_data(exp_data), .tgt_addr(tgt_addr),
        .max_polls(max_polls), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
        .fail(fail), .timeout(timeout)
    );

    always #5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;
    bit wd_hit = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Flash model state
    bit            m_erase;
    logic [DW-1:0] m_goal;
    logic [DW-1:0] m_bad;
    logic [AW-1:0] m_addr;
    int            m_busy_left;
    int            m_glitch;
    bit            m_tgl;
    bit            m_comp;
    int unsigned   m_comp_cyc;
    int unsigned   m_last_ack_cyc;
    int            m_reads;
    int            m_addr_err;
    int            m_watch;
    int            m_gap;
    bit            in_xfer = 1'b0;
    int            lat = 0;

    task automatic make_word(output logic [DW-1:0] w);
        logic [DW-1:0] fin;
        if (m_busy_left > 0) begin
            w = DW'($urandom);
            w[6] = m_tgl;
            m_tgl = ~m_tgl;
            w[7] = m_erase ? 1'b0 : ~m_goal[7];
            m_busy_left--;
        end else begin
            fin = m_goal ^ m_bad;
            if (!m_comp) begin
                m_comp = 1'b1;
                m_comp_cyc = cyc;
            end
            if (cyc < m_comp_cyc + SETTLE + 2) begin
                w = DW'($urandom);
                w[7] = fin[7];
                w[6] = fin[6];
            end else if (m_glitch > 0) begin
                w = fin ^ DW'(1);
                m_glitch--;
            end else begin
                w = fin;
            end
        end
    endtask

    always @(negedge clk) begin
        logic [DW-1:0] w;
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (in_xfer) begin
            if (lat > 0) begin
                lat--;
            end else begin
                make_word(w);
                rd_data = w;
                rd_ack = 1'b1;
                in_xfer = 1'b0;
                m_last_ack_cyc = cyc;
            end
        end else if (rd_req === 1'b1) begin
            m_reads++;
            if (rd_addr !== m_addr) m_addr_err++;
            if (m_reads == m_watch) m_gap = int'(cyc - m_last_ack_cyc);
            in_xfer = 1'b1;
            lat = $urandom_range(0, 3);
        end
    end

    // Reference outcome from the requirements
    task automatic predict(input bit tog, input bit t0, input int b, input int maxp,
                           input bit goal6, input bit bad_nz, input int g,
                           output int reads, output int stop_idx,
                           output bit e_fail, output bit e_tout);
        int inc;
        int m;
        bit lastb;
        if (!tog) begin
            inc = b;
            stop_idx = b + 1;
        end else if (b == 0) begin
            inc = 1;
            stop_idx = 2;
        end else begin
            lastb = t0 ^ bit'((b - 1) & 1);
            if (goal6 == lastb) begin
                inc = b;
                stop_idx = b + 1;
            end else begin
                inc = b + 1;
                stop_idx = b + 2;
            end
        end
        m = (maxp == 0) ? 1 : maxp;
        e_fail = 1'b0;
        e_tout = 1'b0;
        if (inc >= m) begin
            e_tout = 1'b1;
            reads = m;
        end else if (bad_nz) begin
            e_fail = 1'b1;
            reads = stop_idx + 3;
        end else if (g == 0) begin
            reads = stop_idx + 1;
        end else begin
            e_fail = (g >= 2);
            reads = stop_idx + 3;
        end
    endtask

    task automatic run_op(input bit erase, input bit tog, input int b, input int maxp,
                          input logic [DW-1:0] expv, input logic [DW-1:0] bad,
                          input int g, input bit t0, input logic [AW-1:0] addr,
                          input bit stray);
        int e_reads, s_idx, n;
        bit e_fail, e_tout;
        string otag;
        m_erase = erase;
        m_goal = erase ? '1 : expv;
        m_bad = bad;
        m_addr = addr;
        m_busy_left = b;
        m_glitch = g;
        m_tgl = t0;
        m_comp = 1'b0;
        m_reads = 0;
        m_addr_err = 0;
        m_gap = -1;
        predict(tog, t0, b, maxp, m_goal[6], bad != '0, g, e_reads, s_idx, e_fail, e_tout);
        m_watch = e_tout ? -1 : s_idx + 1;
        if (e_tout) otag = "R9";
        else if (bad != '0 || g != 0) otag = "R8";
        else if (tog) otag = "R6";
        else if (erase) otag = "R5";
        else otag = "R4";

        @(negedge clk);
        is_erase = erase;
        use_toggle = tog;
        exp_data = expv;
        tgt_addr = addr;
        max_polls = PW'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 / R10: accepted start sets busy and clears sticky flags
        chk(busy === 1'b1 && fail === 1'b0 && timeout === 1'b0, "R2",
            "busy/flags after start", {busy, fail, timeout}, 3'b100);
        n = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (done === 1'b1 || wd_hit) break;
            n++;
            if (stray && n == 3 && busy === 1'b1) begin
                start = 1'b1;
                tgt_addr = ~addr;
                is_erase = ~erase;
                use_toggle = ~tog;
                max_polls = '1;
            end
        end
        if (wd_hit) return;
        chk(fail === e_fail && timeout === e_tout, otag, "outcome {fail,timeout}",
            {fail, timeout}, {e_fail, e_tout});
        chk(m_reads == e_reads, stray ? "R2" : otag, "read count", m_reads, e_reads);
        chk(m_addr_err == 0, "R3", "reads at wrong address", m_addr_err, 0);
        if (!e_tout) begin
            chk(m_gap == SETTLE + 1, "R7", "verify request gap", m_gap, SETTLE + 1);
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10", "done width / busy after",
            {done, busy}, 0);
        repeat (3) @(negedge clk);
        chk(fail === e_fail && timeout === e_tout && rd_req === 1'b0, "R10",
            "sticky flags while idle", {fail, timeout, rd_req}, {e_fail, e_tout, 1'b0});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        wd_hit = 1'b1;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h00C0FFEE);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk({busy, done, fail, timeout, rd_req} === 5'b0, "R1", "outputs in reset",
            {busy, done, fail, timeout, rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, fail, timeout, rd_req} === 5'b0, "R1", "outputs after reset",
            {busy, done, fail, timeout, rd_req}, 0);

        // Directed corners
        run_op(1'b0, 1'b0, 3, 20, 16'h00A5, '0, 0, 1'b0, 18'h01234, 1'b0); // R4 clean
        run_op(1'b0, 1'b0, 2, 20, 16'h1F2E, '0, 0, 1'b1, 18'h00010, 1'b0); // R4 bit7=0
        run_op(1'b1, 1'b0, 4, 20, 16'h0000, '0, 0, 1'b0, 18'h3FFFF, 1'b0); // R5 exp ignored
        run_op(1'b0, 1'b1, 0, 20, 16'h0040, '0, 0, 1'b1, 18'h00777, 1'b0); // R6 no busy reads
        run_op(1'b0, 1'b1, 5, 20, 16'h0040, '0, 0, 1'b1, 18'h00777, 1'b0); // R6 equal last
        run_op(1'b0, 1'b1, 5, 20, 16'h0000, '0, 0, 1'b1, 18'h00778, 1'b0); // R6 extra read
        run_op(1'b0, 1'b0, 2, 20, 16'h8001, '0, 1, 1'b0, 18'h02000, 1'b0); // R8 race cleared
        run_op(1'b0, 1'b0, 2, 20, 16'h8001, '0, 2, 1'b0, 18'h02001, 1'b0); // R8 rejection real
        run_op(1'b1, 1'b1, 3, 20, 16'h1234, 16'h0003, 0, 1'b0, 18'h02002, 1'b0); // R8 bad data
        run_op(1'b0, 1'b0, 6, 6, 16'h00FF, '0, 0, 1'b0, 18'h04000, 1'b0);  // R9 exact limit
        run_op(1'b0, 1'b0, 6, 7, 16'h00FF, '0, 0, 1'b0, 18'h04001, 1'b0);  // R9 one spare
        run_op(1'b0, 1'b1, 4, 0, 16'h00FF, '0, 0, 1'b0, 18'h04002, 1'b0);  // R9 zero budget
        run_op(1'b0, 1'b0, 8, 30, 16'h5A5A, '0, 0, 1'b1, 18'h0ABCD, 1'b1); // R2 stray start
        run_op(1'b1, 1'b1, 9, 40, 16'h0000, '0, 1, 1'b0, 18'h0ABCE, 1'b1); // R2 stray start

        // Constrained random
        for (int i = 0; i < 24; i++) begin
            bit          r_erase, r_tog, r_t0, r_stray;
            int          r_b, r_max, r_g;
            logic [DW-1:0] r_exp, r_bad;
            logic [AW-1:0] r_addr;
            if (wd_hit) break;
            r_erase = bit'($urandom_range(0, 1));
            r_tog   = bit'($urandom_range(0, 1));
            r_t0    = bit'($urandom_range(0, 1));
            r_stray = ($urandom_range(0, 3) == 0);
            r_b     = $urandom_range(0, 12);
            r_max   = $urandom_range(0, 16);
            r_g     = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
            r_exp   = DW'($urandom);
            r_bad   = ($urandom_range(0, 4) == 0) ? DW'($urandom_range(1, 63)) : '0;
            r_addr  = AW'($urandom);
            run_op(r_erase, r_tog, r_b, r_max, r_exp, r_bad, r_g, r_t0, r_addr, r_stray);
        end

        if (!wd_hit) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule